// File: doc/BRIEF.md
# Interrupted Auto-Precharge Bank Timer

This block lives inside a single-data-rate SDRAM controller. It listens to every command the controller registers (operation, bank, auto-precharge flag and burst length) and keeps, for each bank, the timing of that bank's internal precharge. A burst with auto precharge may be cut short by a READ or WRITE to a different bank. When that happens, the precharge of the first bank moves, and where it moves depends on whether the cut burst was a read or a write. It also depends on what kind of command cut it.

For each bank the block reports three things on registered outputs: a one-cycle pulse when the internal precharge starts, a pulse when the burst stops using the data bus, and a level that shows the bank is idle and may take ACTIVE again. Because it is registered, an event that takes place at clock edge k shows on the outputs in the cycle after edge k. A look-ahead input warns the block two edges before the controller registers a WRITE. If read data is still in flight at that point, the block raises a data-mask request for the two cycles before that WRITE, so that the data bus is never driven from both ends at once.

The clock period (ps), the CAS latency, the bank count and the burst-length width are parameters. The tRAS, tWR and tRP cycle counts are worked out from nanosecond parameters at elaboration.

Top module: `apc_bank_tracker`

## Requirements
- R1: After synchronous reset every bank is ready, no precharge or bus-end pulse is shown, and the mask request is low.
- R2: Command codes on `cmd_op` are 0 none, 1 ACTIVE, 2 READ, 3 WRITE. An ACTIVE to a ready bank drops its ready level in the cycle after the edge. The tRAS, tWR and tRP cycle counts are ceil(ns*1000/CLK_PS), which gives 6, 2 and 3 by default.
- R3: A READ with auto precharge that is not interrupted, registered at edge g with burst length BL, starts precharge at edge g+BL+CL and ends its bus use at that same edge.
- R4: A WRITE with auto precharge that is not interrupted, registered at edge g, starts precharge at edge g+BL-1+tWR (tWR after the last input beat) and ends its bus use at edge g+BL.
- R5: A READ or WRITE to another bank at edge g+i, with 1 <= i < BL, interrupts the burst. When a READ cuts an auto-precharge read, precharge starts at the interrupting edge and read data ends CL edges later.
- R6: When a WRITE cuts an auto-precharge read, precharge starts and the bus use ends at the interrupting edge.
- R7: When a READ or a WRITE cuts an auto-precharge write, the bus use ends at the interrupting edge and precharge starts tWR edges after it.
- R8: Precharge never starts earlier than tRAS edges after the bank's ACTIVE. A start computed earlier than that is held back to exactly that edge.
- R9: The precharge pulse lasts one cycle, and ready rises exactly tRP edges after the precharge start.
- R10: A command to another bank at edge g+BL or later is not an interruption, and the timing of R3/R4 is kept.
- R11: When the write look-ahead is sampled while READ data is outstanding, the mask request is high for exactly the two cycles that follow. READ data counts as outstanding for CL+BL edges after the READ, or until a WRITE is registered.
- R12: When the write look-ahead is sampled with no READ data outstanding, the mask request stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Registered command code (0 none, 1 ACTIVE, 2 READ, 3 WRITE) |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank of the command |
| cmd_ap | input | 1 | Auto-precharge flag of a READ or WRITE |
| cmd_bl | input | BL_W | Burst length in beats (1 or more) |
| wr_ahead | input | 1 | A WRITE will be registered two edges from now |
| pre_start | output | NUM_BANKS | One-cycle pulse per bank when internal precharge starts |
| bus_done | output | NUM_BANKS | One-cycle pulse per bank when its burst stops using the bus |
| bank_ready | output | NUM_BANKS | Bank idle and allowed to take ACTIVE |
| dqm_hi | output | 1 | Data-mask request ahead of an interrupting WRITE |

## Verification
The bench aims at the edges where the four interruption rules differ. A design that mixed up the read and write rules would put precharge tWR edges too early or too late. A design that held back the read-data end on a read-by-write cut would show bus_done CL edges late. An interruption that arrives before tRAS is met must be held back to the tRAS edge, and a design that ignored this would pulse pre_start and raise ready early. A command that lands on the burst's final edge must not count as an interruption, and single-beat bursts must behave the same way. Mask requests are checked both with read data in flight and with none in flight, so a design that masks on every write look-ahead, or that masks for the wrong number of cycles, is caught.

// File: rtl/apc_pkg.sv
package apc_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ACT  = 2'd1,
    OP_RD   = 2'd2,
    OP_WR   = 2'd3
  } apc_op_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_OPEN,
    BK_BURST,
    BK_PRECHG
  } bank_st_e;

  // delay in ns converted to clock cycles, rounded up
  function automatic int ns_to_cycles(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/apc_bank_ctl.sv
module apc_bank_ctl
  import apc_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int BANK_W   = 2,
  parameter int BL_W     = 4,
  parameter int CNT_W    = 6,
  parameter int CAS_LAT  = 3,
  parameter int T_RAS    = 6,
  parameter int T_WR     = 2,
  parameter int T_RP     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  apc_op_e           op,
  input  logic [BANK_W-1:0] bank,
  input  logic              ap,
  input  logic [BL_W-1:0]   bl,
  output logic              pre_start,
  output logic              bus_done,
  output logic              ready
);

  localparam logic [CNT_W-1:0] RAS_C = CNT_W'(T_RAS);
  localparam logic [CNT_W-1:0] WR_C  = CNT_W'(T_WR);
  localparam logic [CNT_W-1:0] RP_C  = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] CL_C  = CNT_W'(CAS_LAT);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  bank_st_e          st;
  logic [CNT_W-1:0]  ras_cnt, pre_cnt, bus_cnt, rp_cnt, beats_left;
  logic              burst_wr;
  logic              own, rdwr, intr, ras_ok;
  logic [CNT_W-1:0]  bl_c;

  assign own    = (bank == BANK_W'(BANK_IDX));
  assign rdwr   = (op == OP_RD) || (op == OP_WR);
  assign intr   = rdwr && !own && (st == BK_BURST) && (beats_left != '0);
  assign ras_ok = (ras_cnt >= RAS_C);
  assign bl_c   = CNT_W'(bl);
  assign ready  = (st == BK_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= BK_IDLE;
      ras_cnt    <= '0;
      pre_cnt    <= '0;
      bus_cnt    <= '0;
      rp_cnt     <= '0;
      beats_left <= '0;
      burst_wr   <= 1'b0;
      pre_start  <= 1'b0;
      bus_done   <= 1'b0;
    end else begin
      pre_start <= 1'b0;
      bus_done  <= 1'b0;
      if (st != BK_IDLE && ras_cnt < RAS_C) ras_cnt <= ras_cnt + ONE;
      if (bus_cnt != '0) begin
        bus_cnt <= bus_cnt - ONE;
        if (bus_cnt == ONE) bus_done <= 1'b1;
      end
      if (beats_left != '0) beats_left <= beats_left - ONE;
      case (st)
        BK_IDLE: begin
          if (op == OP_ACT && own) begin
            st      <= BK_OPEN;
            ras_cnt <= ONE;
          end
        end
        BK_OPEN: begin
          if (rdwr && own && ap) begin
            st         <= BK_BURST;
            burst_wr   <= (op == OP_WR);
            beats_left <= bl_c - ONE;
            pre_cnt    <= (op == OP_WR) ? bl_c + WR_C - ONE : bl_c + CL_C;
            bus_cnt    <= (op == OP_WR) ? bl_c : bl_c + CL_C;
          end
        end
        BK_BURST: begin
          if (intr) begin
            beats_left <= '0;
            if (burst_wr) begin
              // write cut: last beat was the previous cycle, recovery follows
              pre_cnt  <= WR_C;
              bus_cnt  <= '0;
              bus_done <= 1'b1;
            end else begin
              if (op == OP_WR) begin
                bus_cnt  <= '0;
                bus_done <= 1'b1;
              end else begin
                bus_cnt <= CL_C;
              end
              if (ras_ok) begin
                pre_start <= 1'b1;
                st        <= BK_PRECHG;
                rp_cnt    <= RP_C;
              end else begin
                pre_cnt <= ONE;
              end
            end
          end else if (pre_cnt <= ONE) begin
            if (ras_ok) begin
              pre_start <= 1'b1;
              st        <= BK_PRECHG;
              rp_cnt    <= RP_C;
            end
          end else begin
            pre_cnt <= pre_cnt - ONE;
          end
        end
        BK_PRECHG: begin
          if (rp_cnt <= ONE) st <= BK_IDLE;
          else rp_cnt <= rp_cnt - ONE;
        end
        default: st <= BK_IDLE;
      endcase
    end
  end

  // edges since the last precharge pulse, for the tRP check
  logic [CNT_W-1:0] since_pre;
  always_ff @(posedge clk) begin
    if (rst) since_pre <= '0;
    else if (pre_start) since_pre <= ONE;
    else if (since_pre != '0 && since_pre != '1) since_pre <= since_pre + ONE;
  end

  p_pre_after_ras_r8: assert property (@(posedge clk) disable iff (rst)
    pre_start |-> ras_cnt >= RAS_C);
  p_pre_single_r9: assert property (@(posedge clk) disable iff (rst)
    pre_start |=> !pre_start);
  p_ready_after_rp_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> since_pre == RP_C);
  p_act_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ACT && own && ready) |=> !ready);

endmodule

// File: rtl/apc_dqm_guard.sv
module apc_dqm_guard
  import apc_pkg::*;
#(
  parameter int BL_W    = 4,
  parameter int CNT_W   = 6,
  parameter int CAS_LAT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  apc_op_e         op,
  input  logic [BL_W-1:0] bl,
  input  logic            wr_ahead,
  output logic            dqm_hi
);

  localparam logic [CNT_W-1:0] CL_C = CNT_W'(CAS_LAT);

  logic [CNT_W-1:0] rd_left;
  logic [1:0]       mask_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_left  <= '0;
      mask_cnt <= '0;
    end else begin
      if (op == OP_RD) rd_left <= CNT_W'(bl) + CL_C;
      else if (op == OP_WR) rd_left <= '0;
      else if (rd_left != '0) rd_left <= rd_left - CNT_W'(1);

      if (wr_ahead && rd_left != '0) mask_cnt <= 2'd2;
      else if (mask_cnt != '0) mask_cnt <= mask_cnt - 2'd1;
    end
  end

  assign dqm_hi = (mask_cnt != '0);

  p_mask_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(dqm_hi) |-> $past(wr_ahead));
  p_mask_two_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(dqm_hi) |=> dqm_hi);
  p_mask_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_ahead && rd_left == '0 && mask_cnt <= 2'd1) |=> !dqm_hi);

endmodule

// File: rtl/apc_bank_tracker.sv
module apc_bank_tracker
  import apc_pkg::*;
#(
  parameter int CLK_PS    = 7500,
  parameter int CAS_LAT   = 3,
  parameter int NUM_BANKS = 4,
  parameter int BL_W      = 4,
  parameter int TRAS_NS   = 45,
  parameter int TWR_NS    = 14,
  parameter int TRP_NS    = 19
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   cmd_op,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  input  logic                         cmd_ap,
  input  logic [BL_W-1:0]              cmd_bl,
  input  logic                         wr_ahead,
  output logic [NUM_BANKS-1:0]         pre_start,
  output logic [NUM_BANKS-1:0]         bus_done,
  output logic [NUM_BANKS-1:0]         bank_ready,
  output logic                         dqm_hi
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int T_RAS  = ns_to_cycles(TRAS_NS, CLK_PS);
  localparam int T_WR   = ns_to_cycles(TWR_NS, CLK_PS);
  localparam int T_RP   = ns_to_cycles(TRP_NS, CLK_PS);
  localparam int CNT_W  = $clog2((1 << BL_W) + CAS_LAT + T_WR + T_RAS + T_RP + 2);

  apc_op_e op;
  assign op = apc_op_e'(cmd_op);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    apc_bank_ctl #(
      .BANK_IDX (b),
      .BANK_W   (BANK_W),
      .BL_W     (BL_W),
      .CNT_W    (CNT_W),
      .CAS_LAT  (CAS_LAT),
      .T_RAS    (T_RAS),
      .T_WR     (T_WR),
      .T_RP     (T_RP)
    ) u_bank (
      .clk       (clk),
      .rst       (rst),
      .op        (op),
      .bank      (cmd_bank),
      .ap        (cmd_ap),
      .bl        (cmd_bl),
      .pre_start (pre_start[b]),
      .bus_done  (bus_done[b]),
      .ready     (bank_ready[b])
    );
  end

  apc_dqm_guard #(
    .BL_W    (BL_W),
    .CNT_W   (CNT_W),
    .CAS_LAT (CAS_LAT)
  ) u_dqm (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .bl       (cmd_bl),
    .wr_ahead (wr_ahead),
    .dqm_hi   (dqm_hi)
  );

endmodule

// File: tb/tb_apc_bank_tracker.sv
module tb_apc_bank_tracker;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cmd_op = 2'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_ap = 1'b0;
  logic [3:0] cmd_bl = 4'd1;
  logic       wr_ahead = 1'b0;
  logic [3:0] pre_start, bus_done, bank_ready;
  logic       dqm_hi;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  apc_bank_tracker dut (
    .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .cmd_ap(cmd_ap), .cmd_bl(cmd_bl), .wr_ahead(wr_ahead),
    .pre_start(pre_start), .bus_done(bus_done), .bank_ready(bank_ready),
    .dqm_hi(dqm_hi)
  );

  typedef struct packed {
    logic       burst_wr;
    logic [3:0] bl;
    logic [3:0] gap;
    logic [3:0] off;   // 0: no command to bank 1 after the burst
    logic       intr_wr;
    logic [4:0] e_pre;
    logic [4:0] e_bus;
    logic [4:0] e_rdy;
    logic [3:0] req;
  } vec_t;

  // edges counted from the ACTIVE to bank 0 (defaults: CL 3, tRAS 6, tWR 2, tRP 3)
  localparam vec_t VECS [10] = '{
    '{1'b0, 4'd4, 4'd2, 4'd0, 1'b0, 5'd9,  5'd9,  5'd12, 4'd3 },  // R3 plain read
    '{1'b0, 4'd4, 4'd2, 4'd1, 1'b0, 5'd6,  5'd6,  5'd9,  4'd8 },  // R8 read cut early, held to tRAS
    '{1'b0, 4'd4, 4'd6, 4'd2, 1'b0, 5'd8,  5'd11, 5'd11, 4'd5 },  // R5 read by read
    '{1'b0, 4'd8, 4'd6, 4'd3, 1'b1, 5'd9,  5'd9,  5'd12, 4'd6 },  // R6 read by write
    '{1'b1, 4'd4, 4'd2, 4'd0, 1'b0, 5'd7,  5'd6,  5'd10, 4'd4 },  // R4 plain write
    '{1'b1, 4'd4, 4'd6, 4'd1, 1'b0, 5'd9,  5'd7,  5'd12, 4'd7 },  // R7 write by read
    '{1'b1, 4'd8, 4'd6, 4'd4, 1'b1, 5'd12, 5'd10, 5'd15, 4'd7 },  // R7 write by write
    '{1'b1, 4'd2, 4'd2, 4'd1, 1'b0, 5'd6,  5'd3,  5'd9,  4'd8 },  // R8 write cut, tRAS bound
    '{1'b0, 4'd1, 4'd2, 4'd0, 1'b0, 5'd6,  5'd6,  5'd9,  4'd3 },  // R3 single beat
    '{1'b0, 4'd2, 4'd2, 4'd2, 1'b0, 5'd7,  5'd7,  5'd10, 4'd10}   // R10 late command, no cut
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_op = 2'd0; wr_ahead = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input logic [1:0] op, input logic [1:0] bk,
                       input logic ap, input logic [3:0] bl);
    cmd_op = op; cmd_bank = bk; cmd_ap = ap; cmd_bl = bl;
  endtask

  initial begin
    // R1 reset state
    do_reset();
    @(negedge clk);
    chk("R1 ready", int'(bank_ready), 15);
    chk("R1 pre_start", int'(pre_start), 0);
    chk("R1 bus_done", int'(bus_done), 0);
    chk("R1 dqm_hi", int'(dqm_hi), 0);

    for (int v = 0; v < 10; v++) begin
      int pre_at, bus_at, rdy_at, pre_n, bus_n;
      string tag;
      pre_at = -1; bus_at = -1; rdy_at = -1; pre_n = 0; bus_n = 0;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      do_reset();
      for (int e = 0; e < 26; e++) begin
        @(negedge clk);
        if (e > 0) begin
          if (e - 1 == 0) chk({tag, " R2 ready low after ACTIVE"}, int'(bank_ready[0]), 0);
          if (pre_start[0]) begin pre_n++; if (pre_at < 0) pre_at = e - 1; end
          if (bus_done[0]) begin bus_n++; if (bus_at < 0) bus_at = e - 1; end
          if (bank_ready[0] && rdy_at < 0 && e - 1 > 0) rdy_at = e - 1;
        end
        drive(2'd0, 2'd0, 1'b0, 4'd1);
        if (e == 0) drive(2'd1, 2'd0, 1'b0, 4'd1);
        else if (e == 1) drive(2'd1, 2'd1, 1'b0, 4'd1);
        else if (e == int'(VECS[v].gap))
          drive(VECS[v].burst_wr ? 2'd3 : 2'd2, 2'd0, 1'b1, VECS[v].bl);
        else if (VECS[v].off != 0 && e == int'(VECS[v].gap) + int'(VECS[v].off))
          drive(VECS[v].intr_wr ? 2'd3 : 2'd2, 2'd1, 1'b0, 4'd4);
      end
      chk({tag, " precharge edge"}, pre_at, int'(VECS[v].e_pre));
      chk({tag, " bus end edge"}, bus_at, int'(VECS[v].e_bus));
      chk({tag, " R9 ready edge"}, rdy_at, int'(VECS[v].e_rdy));
      chk({tag, " R9 one precharge pulse"}, pre_n, 1);
      chk({tag, " one bus-end pulse"}, bus_n, 1);
    end

    // R11 / R12: mask request with and without read data in flight
    do_reset();
    for (int e = 0; e < 18; e++) begin
      @(negedge clk);
      if (e > 0) begin
        if (e - 1 == 3) chk("R11 mask low before look-ahead", int'(dqm_hi), 0);
        if (e - 1 == 4) chk("R11 mask first cycle", int'(dqm_hi), 1);
        if (e - 1 == 5) chk("R11 mask second cycle", int'(dqm_hi), 1);
        if (e - 1 == 6) chk("R11 mask released", int'(dqm_hi), 0);
        if (e - 1 == 12) chk("R12 no mask when bus idle", int'(dqm_hi), 0);
        if (e - 1 == 13) chk("R12 no mask when bus idle (2)", int'(dqm_hi), 0);
      end
      drive(2'd0, 2'd0, 1'b0, 4'd1);
      wr_ahead = 1'b0;
      if (e == 0) drive(2'd1, 2'd2, 1'b0, 4'd1);
      else if (e == 2) drive(2'd2, 2'd2, 1'b0, 4'd4);
      if (e == 4 || e == 12) wr_ahead = 1'b1;
    end
    chk("R10 bank 2 stays open after plain read", int'(bank_ready[2]), 0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule